// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches an eight-bit port of already-synchronized GPIO inputs and raises interrupts from them. Software picks a trigger for each pin through memory-mapped registers: a high or low level, a rising or falling transition, or any transition. The block combines the detected events with a per-pin enable mask and drives one interrupt line. That line is the OR of every enabled, pending pin.

Level triggers are transparent: the pin's status bit is true exactly while the pin sits at its active level. Edge triggers are sticky: a detected transition sets a status bit. The bit stays set until software writes a one to that pin's position in the clear register. If a clear and a fresh edge land on the same cycle, the edge wins, so no event is lost.

The register interface is a simple single-cycle bus. A write strobe carries an address and data. The read data is a combinational function of the address.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the enable register (0x410), the raw status (0x414), the masked status (0x418) and `irq_out` all read 0. The three trigger registers (0x404, 0x408, 0x40C) also read 0.
- R2: A pin whose mode bit (0x404) is 1 and whose polarity bit (0x40C) is 1 has raw status equal to its pin value. The status follows the pin with no latency.
- R3: A pin whose mode bit is 1 and whose polarity bit is 0 has raw status equal to the inverse of its pin value.
- R4: A pin with mode bit 0, any-edge bit (0x408) 0 and polarity bit 1 sets its raw status on a 0-to-1 pin change. It ignores a 1-to-0 change. The bit is visible after the clock edge that samples the new pin value and stays set while the pin keeps changing.
- R5: A pin with mode bit 0, any-edge bit 0 and polarity bit 0 sets its raw status on a 1-to-0 change only.
- R6: A pin with mode bit 0 and any-edge bit 1 sets its raw status on either change, whatever its polarity bit.
- R7: Masked status (0x418) equals raw status AND the enable register (0x410). `irq_out` is 1 exactly when masked status is non-zero.
- R8: Writing to the clear register (0x41C) clears the latched edge status of each pin whose data bit is 1 and leaves pins with a 0 bit alone. On a level-mode pin held at its active level, the status stays 1.
- R9: When a clear write for a pin and a new qualifying edge on that pin occur in the same cycle, the pin's raw status stays set.
- R10: The clear register reads 0. Writes to 0x414 and 0x418 change neither raw nor masked status.
- R11: The mode, any-edge, polarity and enable registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronized GPIO pin values |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench drives a table of mixed trigger settings. In each row, some pins move the wrong way for their trigger. A design that swaps the polarity sense or lets single-edge pins react to both transitions sets status bits where the table expects none. A directed test puts a clear write and a rising edge in the same cycle. A design that lets the clear take priority loses the event and reads 0. Further tests check three cases:
- A level pin held active survives a clear. A design that stores level events would drop the bit.
- Zero bits in the clear data leave latched bits alone.
- Writes to the status addresses do nothing. A design that decodes those addresses as writable would corrupt the status.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic          irq_out
);
  localparam logic [AW-1:0] A_MODE = AW'('h404);
  localparam logic [AW-1:0] A_ANY  = AW'('h408);
  localparam logic [AW-1:0] A_POL  = AW'('h40C);
  localparam logic [AW-1:0] A_EN   = AW'('h410);
  localparam logic [AW-1:0] A_RAW  = AW'('h414);
  localparam logic [AW-1:0] A_MSK  = AW'('h418);
  localparam logic [AW-1:0] A_CLR  = AW'('h41C);

  logic [N-1:0] mode_q, any_q, pol_q, mask_q;
  logic [N-1:0] prev_pin, edge_lat;
  logic         prev_ok;
  logic [N-1:0] rise, fall, edge_hit, level_hit, clr_vec, raw_stat, masked_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      any_q  <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) mode_q <= bus_wdata;
      if (bus_addr == A_ANY)  any_q  <= bus_wdata;
      if (bus_addr == A_POL)  pol_q  <= bus_wdata;
      if (bus_addr == A_EN)   mask_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pin <= '0;
      prev_ok  <= 1'b0;
      edge_lat <= '0;
    end else begin
      prev_pin <= pin_in;
      prev_ok  <= 1'b1;
      edge_lat <= (edge_lat & ~clr_vec) | edge_hit;
    end
  end

  assign rise      = pin_in & ~prev_pin & {N{prev_ok}};
  assign fall      = ~pin_in & prev_pin & {N{prev_ok}};
  assign edge_hit  = ~mode_q & ((any_q & (rise | fall)) |
                                (~any_q & pol_q & rise) |
                                (~any_q & ~pol_q & fall));
  assign level_hit = mode_q & ~(pin_in ^ pol_q);
  assign clr_vec   = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;

  assign raw_stat    = level_hit | (edge_lat & ~mode_q);
  assign masked_stat = raw_stat & mask_q;
  assign irq_out     = |masked_stat;

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_ANY:   bus_rdata = any_q;
      A_POL:   bus_rdata = pol_q;
      A_EN:    bus_rdata = mask_q;
      A_RAW:   bus_rdata = raw_stat;
      A_MSK:   bus_rdata = masked_stat;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int N  = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_rdata,
  input logic          irq_out,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  edge_lat,
  input logic [N-1:0]  edge_hit,
  input logic [N-1:0]  clr_vec
);
  p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == '0 && edge_lat == '0));

  p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_lat & $past(edge_lat & ~clr_vec)) == $past(edge_lat & ~clr_vec)));

  p_edge_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_lat & ~$past(edge_lat) & ~$past(edge_hit)) == '0));

  p_no_mask_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out);

  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_lat & $past(edge_hit)) == $past(edge_hit)));

  p_clr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'('h41C)) |-> (bus_rdata == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .mask_q(mask_q), .edge_lat(edge_lat),
  .edge_hit(edge_hit), .clr_vec(clr_vec)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = 8'hFF;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  gpio_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #2 clk = ~clk;

  // {mode, any, pol, pins_a, pins_b, expected_raw}
  localparam logic [47:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'hF0, 8'h00, 8'hAA, 8'hA5},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h3C, 8'h3C},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'hF0},
    {8'h00, 8'hFF, 8'h00, 8'h55, 8'h33, 8'h66},
    {8'h0F, 8'h30, 8'h05, 8'hC0, 8'h96, 8'h5C},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h410, r); chk("R1 enable", r, 8'h00);
    rd(12'h414, r); chk("R1 raw", r, 8'h00);
    rd(12'h418, r); chk("R1 masked", r, 8'h00);
    rd(12'h404, r); chk("R1 mode", r, 8'h00);
    rd(12'h408, r); chk("R1 any", r, 8'h00);
    rd(12'h40C, r); chk("R1 pol", r, 8'h00);
    chk("R1 irq", {7'd0, irq_out}, 8'h00);

    // R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < 6; i++) begin
      wr(12'h404, VEC[i][47:40]);
      wr(12'h408, VEC[i][39:32]);
      wr(12'h40C, VEC[i][31:24]);
      pins(VEC[i][23:16]);
      repeat (2) @(negedge clk);
      wr(12'h41C, 8'hFF);
      pins(VEC[i][15:8]);
      @(negedge clk);
      rd(12'h414, r);
      chk($sformatf("R2/R3 R4 R5 R6 row %0d", i), r, VEC[i][7:0]);
      pins(VEC[i][15:8] ^ VEC[i][23:16] ^ VEC[i][15:8]);
      pins(VEC[i][15:8]);
      rd(12'h414, r);
      if (VEC[i][47:40] == 8'h00)
        chk($sformatf("R4 sticky row %0d", i), r & VEC[i][7:0], VEC[i][7:0]);
    end

    // R11 readback
    wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'hFF);
    rd(12'h40C, r); chk("R11 pol readback", r, 8'hFF);
    wr(12'h410, 8'h0C);
    rd(12'h410, r); chk("R11 enable readback", r, 8'h0C);

    // R7 mask and irq
    pins(8'h00); @(negedge clk);
    wr(12'h41C, 8'hFF);
    pins(8'h24); @(negedge clk);
    rd(12'h414, r); chk("R4 raw rising", r, 8'h24);
    rd(12'h418, r); chk("R7 masked", r, 8'h04);
    chk("R7 irq on", {7'd0, irq_out}, 8'h01);
    wr(12'h410, 8'h00);
    chk("R7 irq off", {7'd0, irq_out}, 8'h00);
    rd(12'h418, r); chk("R7 masked off", r, 8'h00);

    // R8 partial clear
    wr(12'h41C, 8'h20);
    rd(12'h414, r); chk("R8 partial clear", r, 8'h04);
    // R10 status writes ignored
    wr(12'h414, 8'hFF); wr(12'h418, 8'hFF);
    rd(12'h414, r); chk("R10 raw unchanged", r, 8'h04);
    rd(12'h418, r); chk("R10 masked unchanged", r, 8'h00);
    rd(12'h41C, r); chk("R10 clear reads zero", r, 8'h00);

    // R8 level pin survives clear
    wr(12'h404, 8'h01); wr(12'h40C, 8'h01);
    pins(8'h01); @(negedge clk);
    wr(12'h41C, 8'hFF);
    @(negedge clk);
    rd(12'h414, r); chk("R8 level held", r, 8'h01);

    // R9 edge and clear in same cycle
    wr(12'h404, 8'h00); wr(12'h40C, 8'hFF);
    pins(8'h00); @(negedge clk);
    wr(12'h41C, 8'hFF);
    rd(12'h414, r); chk("R8 cleared before R9", r, 8'h00);
    @(negedge clk);
    bus_addr = 12'h41C; bus_wdata = 8'h02; bus_wr = 1'b1; pin_in = 8'h02;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(12'h414, r); chk("R9 edge wins", r, 8'h02);

    finish_run();
  end
endmodule